// File: doc/BRIEF.md
# Two-Stage Majority XOR Cell with Parity Chain

This block builds two-input logic from three-input majority voters arranged as a small two-stage pipeline. In the first stage two voters run side by side. One votes on the true operands and one on the complemented operands, and each takes a control bit as its third vote. In the second stage a merging voter combines the two results with a third control bit. Constant control codes make the cell an XOR or an XNOR. When the complement inputs are forced to a constant, the same cell becomes an AND or an OR. Every bit lane of the operand vectors is an independent copy of the cell.

The top level exposes one such cell, configurable per transfer. Next to it, two fixed cells are chained into a 3-input parity generator. The first cell forms a XOR b. The second forms that result XNOR c, with c delayed so that it meets the first cell's result. A valid flag moves through every stage with the data. Synchronous reset clears all flags and all result registers.

Top module: `xormaj_parity_top`

## Requirements
- R1: For every lane the configurable result equals MAJ(MAJ(a, b, c1), c2, MAJ(na, nb, c3)), where c1 = ctrlSel[2], c2 = ctrlSel[1], c3 = ctrlSel[0], and na/nb are the complement operands.
- R2: With ctrlSel = 3'b101 and compForceEn low, each lane of cellOut equals a XOR b.
- R3: With ctrlSel = 3'b010 and compForceEn low, each lane of cellOut equals a XNOR b.
- R4: With compForceEn high, both complement operands of every lane take compForceVal. Value 0 with ctrlSel = 3'b010 gives a AND b, and value 1 with ctrlSel = 3'b101 gives a OR b. Without the force, na = ~a and nb = ~b.
- R5: cellValid rises exactly two clock cycles after inValid is sampled high, and the result for those operands appears in the same cycle.
- R6: parityOut equals ~(a ^ b ^ c) per lane. This is the bit that makes the count of ones among a, b, c and itself odd. It is flagged by parityValid exactly four cycles after inValid is sampled high.
- R7: While rst is high at a clock edge, cellValid, parityValid, cellOut and parityOut are all 0 after that edge.
- R8: In a cycle whose valid flag is low, cellOut and parityOut keep the last valid result, or 0 if none has appeared since reset.
- R9: ctrlSel, compForceEn and compForceVal are sampled together with the operands. Changing them on every transfer does not disturb a result that is already in the pipeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operands on this cycle are to be processed |
| opA | input | WIDTH | Operand a, one bit per lane |
| opB | input | WIDTH | Operand b, one bit per lane |
| opC | input | WIDTH | Third parity operand c |
| ctrlSel | input | 3 | Control votes {c1, c2, c3} of the configurable cell |
| compForceEn | input | 1 | Replace the complement operands with compForceVal |
| compForceVal | input | 1 | Constant driven onto the complement operands when forced |
| cellOut | output | WIDTH | Configurable cell result |
| cellValid | output | 1 | cellOut carries a new result |
| parityOut | output | WIDTH | Parity bit per lane |
| parityValid | output | 1 | parityOut carries a new result |

## Verification
The bench builds the top with WIDTH = 4. Four lanes keep the run short, and a full sweep of a and b over 0 to 15 then places every two-bit input pattern on every lane in each fixed mode. A behavioural queue model predicts both outputs on every cycle. Random control codes, forced complements and gaps in inValid bring the general majority formula and the hold behaviour into reach, and so does a reset issued in the middle of the stream. Because the parity operands are random across sixteen values per lane, every combination of a, b and c reaches the chained cells.

// File: rtl/xormaj_pkg.sv
package xormaj_pkg;

  // Load strobes handed from the control to the datapath, one per clock zone.
  typedef struct packed {
    logic loadZone0;
    logic loadZone1;
  } zone_strobe_t;

  // Control codes {c1, c2, c3}.
  localparam logic [2:0] SEL_XOR  = 3'b101;
  localparam logic [2:0] SEL_XNOR = 3'b010;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/xormaj_cell_ctrl.sv
module xormaj_cell_ctrl
  import xormaj_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output zone_strobe_t strobe,
  output logic         outValid
);

  logic midValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      midValid <= 1'b0;
      outValid <= 1'b0;
    end else begin
      midValid <= inValid;
      outValid <= midValid;
    end
  end

  always_comb begin
    strobe.loadZone0 = inValid;
    strobe.loadZone1 = midValid;
  end

  // R5: a captured transfer reaches the first zone on the next edge
  assert_zone0_follows_R5: assert property (@(posedge clk) disable iff (rst)
    inValid |=> midValid);

  // R5: a transfer leaves the second zone one edge after the first
  assert_zone1_follows_R5: assert property (@(posedge clk) disable iff (rst)
    midValid |=> outValid);

  // R5: no valid flag appears without a preceding transfer
  assert_no_phantom_R5: assert property (@(posedge clk) disable iff (rst)
    !midValid |=> !outValid);

endmodule

// File: rtl/xormaj_cell_dp.sv
module xormaj_cell_dp
  import xormaj_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  zone_strobe_t     strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             forceEn,
  input  logic             forceVal,
  input  logic [2:0]       ctrlSel,
  output logic [WIDTH-1:0] resData
);

  localparam int LANES = WIDTH;

  logic             voteTrue1, voteMerge2, voteComp3;
  logic [LANES-1:0] compA, compB;
  logic [LANES-1:0] leftVote, rightVote;
  logic [LANES-1:0] leftQ, rightQ;
  logic             mergeCtrlQ;
  logic [LANES-1:0] mergeVote;

  assign voteTrue1  = ctrlSel[2];
  assign voteMerge2 = ctrlSel[1];
  assign voteComp3  = ctrlSel[0];

  // Complement operands: inverted inputs, or a forced constant.
  always_comb begin
    if (forceEn) begin
      compA = {LANES{forceVal}};
      compB = {LANES{forceVal}};
    end else begin
      compA = ~opA;
      compB = ~opB;
    end
  end

  // Zone 0: two parallel voters per lane.
  for (genvar lane = 0; lane < LANES; lane++) begin : gZone0
    assign leftVote[lane]  = maj3(opA[lane], opB[lane], voteTrue1);
    assign rightVote[lane] = maj3(compA[lane], compB[lane], voteComp3);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      leftQ      <= '0;
      rightQ     <= '0;
      mergeCtrlQ <= 1'b0;
    end else if (strobe.loadZone0) begin
      leftQ      <= leftVote;
      rightQ     <= rightVote;
      mergeCtrlQ <= voteMerge2;
    end
  end

  // Zone 1: merging voter per lane.
  for (genvar lane = 0; lane < LANES; lane++) begin : gZone1
    assign mergeVote[lane] = maj3(leftQ[lane], mergeCtrlQ, rightQ[lane]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resData <= '0;
    end else if (strobe.loadZone1) begin
      resData <= mergeVote;
    end
  end

  // R8: the result register holds while no transfer leaves the first zone
  assert_hold_result_R8: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadZone1 |=> $stable(resData));

  // R8: the first zone keeps its votes while nothing is captured
  assert_hold_votes_R8: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadZone0 |=> ($stable(leftQ) && $stable(rightQ)));

endmodule

// File: rtl/xormaj_cell.sv
module xormaj_cell
  import xormaj_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       ctrlSel,
  input  logic             forceEn,
  input  logic             forceVal,
  output logic [WIDTH-1:0] resData,
  output logic             resValid
);

  zone_strobe_t strobe;

  xormaj_cell_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (resValid)
  );

  xormaj_cell_dp #(.WIDTH(WIDTH)) uDp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .forceEn  (forceEn),
    .forceVal (forceVal),
    .ctrlSel  (ctrlSel),
    .resData  (resData)
  );

endmodule

// File: rtl/xormaj_parity_top.sv
module xormaj_parity_top
  import xormaj_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opC,
  input  logic [2:0]       ctrlSel,
  input  logic             compForceEn,
  input  logic             compForceVal,
  output logic [WIDTH-1:0] cellOut,
  output logic             cellValid,
  output logic [WIDTH-1:0] parityOut,
  output logic             parityValid
);

  localparam int CELL_LATENCY = 2;

  // Configurable cell.
  xormaj_cell #(.WIDTH(WIDTH)) uCfgCell (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .opA      (opA),
    .opB      (opB),
    .ctrlSel  (ctrlSel),
    .forceEn  (compForceEn),
    .forceVal (compForceVal),
    .resData  (cellOut),
    .resValid (cellValid)
  );

  // Parity chain: first cell a XOR b.
  logic [WIDTH-1:0] xorData;
  logic             xorValid;

  xormaj_cell #(.WIDTH(WIDTH)) uXorCell (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .opA      (opA),
    .opB      (opB),
    .ctrlSel  (SEL_XOR),
    .forceEn  (1'b0),
    .forceVal (1'b0),
    .resData  (xorData),
    .resValid (xorValid)
  );

  // c is delayed by one cell latency. The valid pipeline never stalls,
  // so a free-running shift lines up with every valid xor result.
  logic [WIDTH-1:0] cDelay [CELL_LATENCY];

  for (genvar st = 0; st < CELL_LATENCY; st++) begin : gCDelay
    always_ff @(posedge clk) begin
      if (rst) begin
        cDelay[st] <= '0;
      end else begin
        cDelay[st] <= (st == 0) ? opC : cDelay[(st == 0) ? 0 : st - 1];
      end
    end
  end

  // Second cell: (a XOR b) XNOR c.
  xormaj_cell #(.WIDTH(WIDTH)) uXnorCell (
    .clk      (clk),
    .rst      (rst),
    .inValid  (xorValid),
    .opA      (xorData),
    .opB      (cDelay[CELL_LATENCY-1]),
    .ctrlSel  (SEL_XNOR),
    .forceEn  (1'b0),
    .forceVal (1'b0),
    .resData  (parityOut),
    .resValid (parityValid)
  );

  // R2: XOR code without force yields a XOR b two cycles later
  assert_xor_mode_R2: assert property (@(posedge clk) disable iff (rst)
    (cellValid && ($past(ctrlSel, 2) == SEL_XOR) && !$past(compForceEn, 2))
      |-> (cellOut == ($past(opA, 2) ^ $past(opB, 2))));

  // R3: XNOR code without force yields a XNOR b two cycles later
  assert_xnor_mode_R3: assert property (@(posedge clk) disable iff (rst)
    (cellValid && ($past(ctrlSel, 2) == SEL_XNOR) && !$past(compForceEn, 2))
      |-> (cellOut == ~($past(opA, 2) ^ $past(opB, 2))));

  // R6: parity result of the operands taken four cycles earlier
  assert_parity_R6: assert property (@(posedge clk) disable iff (rst)
    parityValid |-> (parityOut == ~($past(opA, 4) ^ $past(opB, 4) ^ $past(opC, 4))));

  // R6: parity flag follows the cell flag by exactly two cycles
  assert_parity_latency_R6: assert property (@(posedge clk) disable iff (rst)
    cellValid |=> ##1 parityValid);

endmodule

// File: tb/xormaj_parity_top_test.sv
`timescale 1ns/1ps
module xormaj_parity_top_test;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [W-1:0] opA = '0, opB = '0, opC = '0;
  logic [2:0]   ctrlSel = '0;
  logic         compForceEn = 1'b0, compForceVal = 1'b0;
  logic [W-1:0] cellOut, parityOut;
  logic         cellValid, parityValid;

  xormaj_parity_top #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .inValid(inValid),
    .opA(opA), .opB(opB), .opC(opC),
    .ctrlSel(ctrlSel), .compForceEn(compForceEn), .compForceVal(compForceVal),
    .cellOut(cellOut), .cellValid(cellValid),
    .parityOut(parityOut), .parityValid(parityValid)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [W:0]   cellQ[$];
  string        tagQ[$];
  logic [W:0]   parQ[$];
  logic [W-1:0] lastCell, lastPar;

  task automatic fail(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
    fails++;
    $display("FAIL %s: %s actual=%h expected=%h", tag, what, act, expv);
  endtask

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) fail(tag, what, act, expv);
  endtask

  function automatic bit vote(input logic x, input logic y, input logic z);
    int n;
    n = int'(x) + int'(y) + int'(z);
    return n >= 2;
  endfunction

  // Expected configurable result, from the requirements.
  function automatic logic [W-1:0] cellModel(input logic [W-1:0] a, input logic [W-1:0] b,
      input logic [2:0] sel, input logic fen, input logic fval);
    logic [W-1:0] r;
    if (!fen && sel == 3'b101) return a ^ b;                 // R2
    if (!fen && sel == 3'b010) return ~(a ^ b);              // R3
    if (fen && !fval && sel == 3'b010) return a & b;         // R4
    if (fen && fval && sel == 3'b101) return a | b;          // R4
    for (int i = 0; i < W; i++) begin                        // R1
      logic na, nb, l, rr;
      na = fen ? fval : ~a[i];
      nb = fen ? fval : ~b[i];
      l  = vote(a[i], b[i], sel[2]);
      rr = vote(na, nb, sel[0]);
      r[i] = vote(l, sel[1], rr);
    end
    return r;
  endfunction

  function automatic string tagFor(input logic [2:0] sel, input logic fen, input logic fval);
    if (!fen && sel == 3'b101) return "R2";
    if (!fen && sel == 3'b010) return "R3";
    if (fen && ((!fval && sel == 3'b010) || (fval && sel == 3'b101))) return "R4";
    return "R1";
  endfunction

  task automatic modelReset();
    cellQ.delete(); tagQ.delete(); parQ.delete();
    repeat (2) begin cellQ.push_back('0); tagQ.push_back("R5"); end
    repeat (4) parQ.push_back('0);
    lastCell = '0;
    lastPar  = '0;
  endtask

  // One cycle: check outputs at the negedge, then drive the next transfer.
  task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic [W-1:0] c, input logic [2:0] sel,
                      input logic fen, input logic fval);
    logic [W:0] ec, ep;
    string tg;
    @(negedge clk);
    ec = cellQ.pop_front();
    tg = tagQ.pop_front();
    ep = parQ.pop_front();
    check("R5", "cellValid", 32'(cellValid), 32'(ec[W]));
    if (ec[W]) begin
      check(tg, "cellOut", 32'(cellOut), 32'(ec[W-1:0]));
      lastCell = ec[W-1:0];
    end else begin
      check("R8", "cellOut hold", 32'(cellOut), 32'(lastCell));
    end
    check("R6", "parityValid", 32'(parityValid), 32'(ep[W]));
    if (ep[W]) begin
      check("R6", "parityOut", 32'(parityOut), 32'(ep[W-1:0]));
      lastPar = ep[W-1:0];
    end else begin
      check("R8", "parityOut hold", 32'(parityOut), 32'(lastPar));
    end
    rst = 1'b0;
    inValid = v; opA = a; opB = b; opC = c;
    ctrlSel = sel; compForceEn = fen; compForceVal = fval;
    cellQ.push_back({v, cellModel(a, b, sel, fen, fval)});
    tagQ.push_back(tagFor(sel, fen, fval));
    parQ.push_back({v, ~(a ^ b ^ c)});
  endtask

  // R7: reset clears flags and results, even with traffic on the inputs.
  task automatic doReset(input int n);
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b1; opA = 4'hF; opB = 4'h5; opC = 4'h3; ctrlSel = 3'b111;
    repeat (n) begin
      @(negedge clk);
      check("R7", "cellValid in reset", 32'(cellValid), 0);
      check("R7", "parityValid in reset", 32'(parityValid), 0);
      check("R7", "cellOut in reset", 32'(cellOut), 0);
      check("R7", "parityOut in reset", 32'(parityOut), 0);
    end
    modelReset();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    doReset(3);

    // R2, R3, R4: sweep every operand pair in each fixed mode.
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          case (m)
            0: step(1'b1, W'(a), W'(b), W'($urandom), 3'b101, 1'b0, 1'b0);
            1: step(1'b1, W'(a), W'(b), W'($urandom), 3'b010, 1'b0, 1'b0);
            2: step(1'b1, W'(a), W'(b), W'($urandom), 3'b010, 1'b1, 1'b0);
            default: step(1'b1, W'(a), W'(b), W'($urandom), 3'b101, 1'b1, 1'b1);
          endcase
        end
      end
    end

    // R1, R8, R9: random codes and forces on every transfer, with gaps.
    for (int k = 0; k < 3000; k++) begin
      step(($urandom % 10) < 7, W'($urandom), W'($urandom), W'($urandom),
           3'($urandom), 1'($urandom), 1'($urandom));
    end

    // R7: reset in the middle of a stream, then resume.
    doReset(2);
    for (int k = 0; k < 1000; k++) begin
      step(($urandom % 4) != 0, W'($urandom), W'($urandom), W'($urandom),
           3'($urandom), 1'($urandom), 1'($urandom));
    end

    // R8: drain with no transfers; outputs must hold the last results.
    for (int k = 0; k < 8; k++) begin
      step(1'b0, W'($urandom), W'($urandom), W'($urandom), 3'($urandom), 1'b0, 1'b0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule